// File: doc/BRIEF.md
# Scalar Floating-Point Compare Flag Unit

This unit compares two IEEE-754 scalar operands and turns the relation between them into a three-bit condition code held in a small flag register. Each operand arrives on a 64-bit bus. A precision select decides whether the low 32 bits are read as a single-precision value or all 64 bits as a double-precision value. The relation is one of unordered, greater, less or equal, and it is written as zero, parity and carry flags. The overflow, sign and auxiliary-carry flags are cleared by every compare that commits.

The unit also reports two exceptions: an invalid indication for NaN inputs and a denormal indication for subnormal inputs. A policy input chooses how NaNs raise the invalid indication. In signaling policy any NaN raises it. In quiet policy only a signaling NaN raises it. Each exception has a mask bit. When an exception is raised and its mask bit is low, the flag register keeps its old value, but the exception outputs still report what happened. Operands and controls are sampled on a clock edge when the strobe is high, and the results appear one cycle after they are presented.

Top module: `fcmp_flag_unit`

## Requirements
- R1: The relation is unordered when either operand is a NaN, quiet or signaling. A NaN has an all-ones exponent and a nonzero mantissa. It is signaling when its top mantissa bit is 0.
- R2: The flags {zero, parity, carry} are 111 for unordered, 000 for greater, 001 for less and 100 for equal. No other combination ever appears.
- R3: The overflow, sign and auxiliary-carry outputs are 0 after reset and after every compare.
- R4: With sig_mode_i = 1, the invalid indication is raised when either operand is any NaN.
- R5: With sig_mode_i = 0, the invalid indication is raised only when an operand is a signaling NaN. A quiet NaN alone leaves it low.
- R6: If a raised exception has its mask input at 0, the six flags keep their previous values on that strobe. The exception outputs still update.
- R7: The denormal indication is raised when either operand is subnormal, meaning a zero exponent and a nonzero mantissa. Zero itself is not subnormal.
- R8: With dbl_i = 0, only bits 31:0 of each operand are used and bits 63:32 have no effect. With dbl_i = 1, all 64 bits are used.
- R9: Positive zero and negative zero compare as equal.
- R10: Non-NaN values are ordered by sign and magnitude. Any positive value is greater than any negative value. Between two negatives the larger magnitude is the smaller value. Infinities order as the largest magnitudes.
- R11: A high vld_i at a rising edge loads the flags and the exception outputs, so results are visible after that edge and not before it. With vld_i low, all outputs hold.
- R12: A synchronous low rst_n clears all eight outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_i | input | 1 | Strobe: sample the operands and update the outputs |
| dbl_i | input | 1 | 1 = double precision (64-bit), 0 = single precision (low 32 bits) |
| sig_mode_i | input | 1 | 1 = any NaN raises invalid, 0 = only a signaling NaN raises it |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| msk_inv_i | input | 1 | Invalid mask; 1 = masked, flags still update |
| msk_den_i | input | 1 | Denormal mask; 1 = masked, flags still update |
| flag_zf_o | output | 1 | Zero flag |
| flag_pf_o | output | 1 | Parity flag |
| flag_cf_o | output | 1 | Carry flag |
| flag_of_o | output | 1 | Overflow flag, cleared by compares |
| flag_sf_o | output | 1 | Sign flag, cleared by compares |
| flag_af_o | output | 1 | Auxiliary-carry flag, cleared by compares |
| exc_inv_o | output | 1 | Invalid indication of the last strobe |
| exc_den_o | output | 1 | Denormal indication of the last strobe |

## Verification
The compare is driven in both precisions with these operand pairs:
- Equal values and reversed pairs, which separate greater from less.
- Two negatives, which catch a magnitude order that was not reversed.
- Opposite-sign pairs, including the two zeros, which catch a sign decided only by magnitude.
- Infinities.

Quiet and signaling NaNs are each applied under both policies and both mask settings. This separates the invalid rule of each policy and shows whether a flag update is suppressed or allowed. In single mode, operands with different upper words but equal low words show that the upper bits are ignored. A low word that is normal as a single but forms a double subnormal shows that the precision select changes the decode.

// File: rtl/fcmp_pkg.sv
// Package: shared format widths, relation type and condition-code mapping
// for the scalar compare flag unit.
package fcmp_pkg;

    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W;
    localparam int MAG_W    = DP_W - 1;
    localparam int N_OPS    = 2;

    typedef enum logic [1:0] {
        REL_UN = 2'd0,
        REL_GT = 2'd1,
        REL_LT = 2'd2,
        REL_EQ = 2'd3
    } rel_e;

    typedef struct packed {
        logic zf;
        logic pf;
        logic cf;
    } ccode_t;

    // Fixed mapping from relation to {zero, parity, carry}.
    function automatic ccode_t rel_to_code(input rel_e r);
        ccode_t c;
        case (r)
            REL_UN:  c = '{zf: 1'b1, pf: 1'b1, cf: 1'b1};
            REL_GT:  c = '{zf: 1'b0, pf: 1'b0, cf: 1'b0};
            REL_LT:  c = '{zf: 1'b0, pf: 1'b0, cf: 1'b1};
            default: c = '{zf: 1'b1, pf: 1'b0, cf: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fcmp_fmt_decode.sv
// Module: fcmp_fmt_decode
// Splits one IEEE-754 value of a given exponent/mantissa width into sign and
// magnitude and classifies it as NaN, signaling NaN or subnormal.
// Assumes: the top mantissa bit is the quiet bit; a value is NaN when its
// exponent is all ones and its mantissa nonzero.
module fcmp_fmt_decode #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] val_i,
    output logic         sign_o,
    output logic [W-2:0] mag_o,
    output logic         nan_o,
    output logic         snan_o,
    output logic         den_o
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             man_nz;

    // Field extraction and classification.
    always_comb begin
        exp_f  = val_i[W-2 -: EXP_W];
        man_f  = val_i[MAN_W-1:0];
        man_nz = |man_f;
        sign_o = val_i[W-1];
        mag_o  = val_i[W-2:0];
        nan_o  = (&exp_f) & man_nz;
        snan_o = (&exp_f) & man_nz & ~man_f[MAN_W-1];
        den_o  = ~(|exp_f) & man_nz;
    end

endmodule

// File: rtl/fcmp_operand.sv
// Module: fcmp_operand
// Decodes one 64-bit operand bus in both precisions and selects the view
// chosen by the precision input. Single mode reads only the low word.
// Assumes: single magnitudes are zero-extended to the double magnitude width.
module fcmp_operand
    import fcmp_pkg::*;
(
    input  logic [DP_W-1:0]  op_i,
    input  logic             dbl_i,
    output logic             sign_o,
    output logic [MAG_W-1:0] mag_o,
    output logic             nan_o,
    output logic             snan_o,
    output logic             den_o
);

    localparam int SP_MAG_W = SP_W - 1;

    logic                sp_sign, sp_nan, sp_snan, sp_den;
    logic [SP_MAG_W-1:0] sp_mag;
    logic                dp_sign, dp_nan, dp_snan, dp_den;
    logic [MAG_W-1:0]    dp_mag;

    fcmp_fmt_decode #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp (
        .val_i  (op_i[SP_W-1:0]),
        .sign_o (sp_sign),
        .mag_o  (sp_mag),
        .nan_o  (sp_nan),
        .snan_o (sp_snan),
        .den_o  (sp_den)
    );

    fcmp_fmt_decode #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp (
        .val_i  (op_i),
        .sign_o (dp_sign),
        .mag_o  (dp_mag),
        .nan_o  (dp_nan),
        .snan_o (dp_snan),
        .den_o  (dp_den)
    );

    // Precision select.
    always_comb begin
        if (dbl_i) begin
            sign_o = dp_sign;
            mag_o  = dp_mag;
            nan_o  = dp_nan;
            snan_o = dp_snan;
            den_o  = dp_den;
        end else begin
            sign_o = sp_sign;
            mag_o  = {{(MAG_W-SP_MAG_W){1'b0}}, sp_mag};
            nan_o  = sp_nan;
            snan_o = sp_snan;
            den_o  = sp_den;
        end
    end

endmodule

// File: rtl/fcmp_order.sv
// Module: fcmp_order
// Orders two non-NaN values by sign and magnitude; forces unordered when the
// caller flags a NaN. Both zeros compare equal regardless of sign.
// Assumes: magnitudes are exponent:mantissa, so integer order = value order.
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MW = MAG_W
) (
    input  logic          sign_a_i,
    input  logic          sign_b_i,
    input  logic [MW-1:0] mag_a_i,
    input  logic [MW-1:0] mag_b_i,
    input  logic          unord_i,
    output rel_e          rel_o
);

    logic both_zero;
    logic a_bigger;

    // Relation decision.
    always_comb begin
        both_zero = ~(|mag_a_i) & ~(|mag_b_i);
        a_bigger  = mag_a_i > mag_b_i;
        if (unord_i)
            rel_o = REL_UN;
        else if (both_zero)
            rel_o = REL_EQ;
        else if (sign_a_i != sign_b_i)
            rel_o = sign_a_i ? REL_LT : REL_GT;
        else if (mag_a_i == mag_b_i)
            rel_o = REL_EQ;
        else if (a_bigger ^ sign_a_i)
            rel_o = REL_GT;
        else
            rel_o = REL_LT;
    end

endmodule

// File: rtl/fcmp_flag_unit.sv
// Module: fcmp_flag_unit (top)
// Compares two scalar operands and registers the condition code, the three
// cleared flags and the invalid/denormal indications on a strobe. An
// exception whose mask is low blocks the flag update but is still reported.
// Assumes: synchronous active-low reset; one compare per strobe.
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld_i,
    input  logic            dbl_i,
    input  logic            sig_mode_i,
    input  logic [DP_W-1:0] opa_i,
    input  logic [DP_W-1:0] opb_i,
    input  logic            msk_inv_i,
    input  logic            msk_den_i,
    output logic            flag_zf_o,
    output logic            flag_pf_o,
    output logic            flag_cf_o,
    output logic            flag_of_o,
    output logic            flag_sf_o,
    output logic            flag_af_o,
    output logic            exc_inv_o,
    output logic            exc_den_o
);

    logic [DP_W-1:0]  ops    [N_OPS];
    logic [N_OPS-1:0] sign_v;
    logic [N_OPS-1:0] nan_v;
    logic [N_OPS-1:0] snan_v;
    logic [N_OPS-1:0] den_v;
    logic [MAG_W-1:0] mag_v  [N_OPS];

    rel_e   rel_c;
    ccode_t code_c;
    ccode_t cc_q;
    logic   unord_c, inv_c, den_c, block_c;
    logic   of_q, sf_q, af_q, inv_q, den_q;

    assign ops[0] = opa_i;
    assign ops[1] = opb_i;

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        fcmp_operand u_op (
            .op_i   (ops[i]),
            .dbl_i  (dbl_i),
            .sign_o (sign_v[i]),
            .mag_o  (mag_v[i]),
            .nan_o  (nan_v[i]),
            .snan_o (snan_v[i]),
            .den_o  (den_v[i])
        );
    end

    fcmp_order #(.MW(MAG_W)) u_order (
        .sign_a_i (sign_v[0]),
        .sign_b_i (sign_v[1]),
        .mag_a_i  (mag_v[0]),
        .mag_b_i  (mag_v[1]),
        .unord_i  (unord_c),
        .rel_o    (rel_c)
    );

    // Exception detection and update gating.
    always_comb begin
        unord_c = |nan_v;
        inv_c   = sig_mode_i ? (|nan_v) : (|snan_v);
        den_c   = |den_v;
        block_c = (inv_c & ~msk_inv_i) | (den_c & ~msk_den_i);
        code_c  = rel_to_code(rel_c);
    end

    // Flag and exception registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q  <= '0;
            of_q  <= 1'b0;
            sf_q  <= 1'b0;
            af_q  <= 1'b0;
            inv_q <= 1'b0;
            den_q <= 1'b0;
        end else if (vld_i) begin
            inv_q <= inv_c;
            den_q <= den_c;
            if (!block_c) begin
                cc_q <= code_c;
                of_q <= 1'b0;
                sf_q <= 1'b0;
                af_q <= 1'b0;
            end
        end
    end

    assign flag_zf_o = cc_q.zf;
    assign flag_pf_o = cc_q.pf;
    assign flag_cf_o = cc_q.cf;
    assign flag_of_o = of_q;
    assign flag_sf_o = sf_q;
    assign flag_af_o = af_q;
    assign exc_inv_o = inv_q;
    assign exc_den_o = den_q;

endmodule

// File: rtl/fcmp_flag_unit_chk.sv
// Module: fcmp_flag_unit_chk
// Property checker for fcmp_flag_unit, attached by bind below. Relates the
// decode-side exception signals to the registered flags and outputs.
module fcmp_flag_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic vld_i,
    input logic msk_inv_i,
    input logic msk_den_i,
    input logic unord_c,
    input logic inv_c,
    input logic den_c,
    input logic flag_zf_o,
    input logic flag_pf_o,
    input logic flag_cf_o,
    input logic flag_of_o,
    input logic flag_sf_o,
    input logic flag_af_o,
    input logic exc_inv_o,
    input logic exc_den_o
);

    logic blk;
    // Unmasked-exception condition as seen by the checker.
    always_comb blk = (inv_c && !msk_inv_i) || (den_c && !msk_den_i);

    p_code_pf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pf_o |-> (flag_zf_o && flag_cf_o));

    p_code_zf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_zf_o && !flag_pf_o) |-> !flag_cf_o);

    p_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_of_o || flag_sf_o || flag_af_o));

    p_unordered_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && unord_c && !blk) |=> (flag_zf_o && flag_pf_o && flag_cf_o));

    p_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && blk) |=> $stable({flag_zf_o, flag_pf_o, flag_cf_o}));

    p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (exc_inv_o == $past(inv_c)) && (exc_den_o == $past(den_c)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable({flag_zf_o, flag_pf_o, flag_cf_o, exc_inv_o, exc_den_o}));

endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld_i     (vld_i),
    .msk_inv_i (msk_inv_i),
    .msk_den_i (msk_den_i),
    .unord_c   (unord_c),
    .inv_c     (inv_c),
    .den_c     (den_c),
    .flag_zf_o (flag_zf_o),
    .flag_pf_o (flag_pf_o),
    .flag_cf_o (flag_cf_o),
    .flag_of_o (flag_of_o),
    .flag_sf_o (flag_sf_o),
    .flag_af_o (flag_af_o),
    .exc_inv_o (exc_inv_o),
    .exc_den_o (exc_den_o)
);

// File: tb/sim_fcmp_flag_unit.sv
// Bench for fcmp_flag_unit: a vector table walked in one loop, then directed
// checks for reset, latency and hold without strobe.
module sim_fcmp_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        vld, dbl, sig;
    logic [63:0] opa, opb;
    logic        minv, mden;
    logic        zf, pf, cf, of_f, sf_f, af_f, einv, eden;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    fcmp_flag_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (vld),
        .dbl_i      (dbl),
        .sig_mode_i (sig),
        .opa_i      (opa),
        .opb_i      (opb),
        .msk_inv_i  (minv),
        .msk_den_i  (mden),
        .flag_zf_o  (zf),
        .flag_pf_o  (pf),
        .flag_cf_o  (cf),
        .flag_of_o  (of_f),
        .flag_sf_o  (sf_f),
        .flag_af_o  (af_f),
        .exc_inv_o  (einv),
        .exc_den_o  (eden)
    );

    typedef struct packed {
        logic        dbl;
        logic        sig;
        logic [63:0] a;
        logic [63:0] b;
        logic        minv;
        logic        mden;
        logic [2:0]  code;   // expected {zf,pf,cf} if the update commits
        logic        inv;
        logic        den;
        logic        upd;    // 1 = flags take code, 0 = flags keep old value
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        // R10 less / greater
        '{1'b0,1'b0,64'h3F800000,64'h40000000,1'b1,1'b1,3'b001,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,64'h40000000,64'h3F800000,1'b1,1'b1,3'b000,1'b0,1'b0,1'b1},
        // R2 equal
        '{1'b0,1'b0,64'h3F800000,64'h3F800000,1'b1,1'b1,3'b100,1'b0,1'b0,1'b1},
        // R10 two negatives reversed, mixed signs, infinity
        '{1'b0,1'b0,64'hBF800000,64'hC0000000,1'b1,1'b1,3'b000,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,64'hC0000000,64'h3F800000,1'b1,1'b1,3'b001,1'b0,1'b0,1'b1},
        // R9 +0 vs -0
        '{1'b0,1'b0,64'h00000000,64'h80000000,1'b1,1'b1,3'b100,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,64'h7F800000,64'h40000000,1'b1,1'b1,3'b000,1'b0,1'b0,1'b1},
        // R1/R5 quiet policy, quiet NaN unmasked: no invalid, unordered
        '{1'b0,1'b0,64'h7FC00000,64'h3F800000,1'b0,1'b1,3'b111,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,64'h3F800000,64'h40000000,1'b1,1'b1,3'b001,1'b0,1'b0,1'b1},
        // R4/R6 signaling policy, quiet NaN unmasked: invalid, flags held
        '{1'b0,1'b1,64'h3F800000,64'h7FC00000,1'b0,1'b1,3'b111,1'b1,1'b0,1'b0},
        // R4 masked: invalid, flags updated
        '{1'b0,1'b1,64'h7FC00000,64'h3F800000,1'b1,1'b1,3'b111,1'b1,1'b0,1'b1},
        '{1'b0,1'b0,64'h40000000,64'h3F800000,1'b1,1'b1,3'b000,1'b0,1'b0,1'b1},
        // R5/R6 quiet policy, signaling NaN unmasked: invalid, flags held
        '{1'b0,1'b0,64'h7F800001,64'h3F800000,1'b0,1'b1,3'b111,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,64'h7F800001,64'h7F800001,1'b1,1'b1,3'b111,1'b1,1'b0,1'b1},
        // R7 subnormal vs zero, masked
        '{1'b0,1'b0,64'h00000001,64'h00000000,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1},
        '{1'b0,1'b0,64'h3F800000,64'h40000000,1'b1,1'b1,3'b001,1'b0,1'b0,1'b1},
        // R7/R6 negative subnormal, unmasked: flags held
        '{1'b0,1'b0,64'h00000000,64'h80000001,1'b1,1'b0,3'b000,1'b0,1'b1,1'b0},
        // R8 single mode ignores upper word
        '{1'b0,1'b0,64'hFFFFFFFF3F800000,64'h123456783F800000,1'b1,1'b1,3'b100,1'b0,1'b0,1'b1},
        // double precision
        '{1'b1,1'b0,64'h3FF0000000000000,64'h4000000000000000,1'b1,1'b1,3'b001,1'b0,1'b0,1'b1},
        '{1'b1,1'b0,64'h4000000000000000,64'hC000000000000000,1'b1,1'b1,3'b000,1'b0,1'b0,1'b1},
        '{1'b1,1'b0,64'h7FF8000000000000,64'h3FF0000000000000,1'b0,1'b1,3'b111,1'b0,1'b0,1'b1},
        '{1'b1,1'b1,64'h7FF0000000000001,64'h3FF0000000000000,1'b1,1'b1,3'b111,1'b1,1'b0,1'b1},
        // R8 double mode: low word alone is a double subnormal
        '{1'b1,1'b0,64'h000000003F800000,64'h0000000000000000,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1},
        '{1'b1,1'b0,64'hC000000000000000,64'hC000000000000000,1'b1,1'b1,3'b100,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,64'h7F800000,64'h7F800000,1'b1,1'b1,3'b100,1'b0,1'b0,1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp_v);
        end
    endtask

    function automatic logic [7:0] outs();
        return {zf, pf, cf, of_f, sf_f, af_f, einv, eden};
    endfunction

    task automatic drive(input vec_t v, input logic strobe);
        vld  = strobe;
        dbl  = v.dbl;
        sig  = v.sig;
        opa  = v.a;
        opb  = v.b;
        minv = v.minv;
        mden = v.mden;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [2:0] exp_cc;
        logic       exp_inv, exp_den;
        rst_n = 1'b0;
        drive(VEC[0], 1'b0);
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset", outs(), 8'h00);
        rst_n = 1'b1;
        exp_cc = 3'b000;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i], 1'b1);
            @(negedge clk);
            vld = 1'b0;
            if (VEC[i].upd) exp_cc = VEC[i].code;
            exp_inv = VEC[i].inv;
            exp_den = VEC[i].den;
            // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 per table entry
            check($sformatf("R2/R6 vec%0d flags", i), {5'd0, zf, pf, cf}, {5'd0, exp_cc});
            check($sformatf("R3 vec%0d cleared", i), {5'd0, of_f, sf_f, af_f}, 8'h00);
            check($sformatf("R4/R5/R7 vec%0d exc", i), {6'd0, einv, eden}, {6'd0, exp_inv, exp_den});
        end

        // R11 hold with strobe low: flags 100, exc 00 after last vector
        drive(VEC[12], 1'b0);
        repeat (3) @(negedge clk);
        check("R11 hold no strobe", outs(), {3'b100, 3'b000, 2'b00});

        // R11 latency: not visible before the edge, visible after it
        drive(VEC[0], 1'b1);
        #1;
        check("R11 before edge", outs(), {3'b100, 3'b000, 2'b00});
        @(negedge clk);
        vld = 1'b0;
        check("R11 after edge", outs(), {3'b001, 3'b000, 2'b00});

        // R12 reset mid-run clears flags and exceptions
        drive(VEC[13], 1'b1);
        @(negedge clk);
        vld = 1'b0;
        check("R1 setup before reset", outs(), {3'b111, 3'b000, 2'b10});
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R12 mid-run reset", outs(), 8'h00);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule